// File: doc/BRIEF.md
# Emulated Flash Status Register

This block holds the status word that an emulated serial NOR flash reports to its host. The word is three status bytes joined into one 24-bit value. Bit 0 is the busy flag and bit 1 is the write-enable latch (WEL). Upstream logic shifts bits and decodes opcodes. It then presents one completion strobe per finished command, together with the command's opcode and the busy attribute taken from the command's slot. From those strobes the block sets or clears WEL for the configured write-enable and write-disable opcodes, and it raises busy for commands marked as busy-setting.

Local software has three actions. It can overwrite the whole word. It can clear busy and WEL together in one action. It can cancel a request that is still waiting. While the host has a transaction open (`hostActive` high), a software request is not applied. It waits as a single pending request, and a later request replaces an earlier one. The pending request is applied in the first cycle in which the host is idle. When the host starts a read-status command, the block captures the selected status byte once. That byte stays on `hostByte` until the next read-status start, so the value the host shifts out cannot change part way through.

Top module: `flash_status_emu`

## Requirements
- R1: After reset, `statusOut` is 0x000000 and `hostByte` is 0x00.
- R2: Bit 0 of `statusOut` is busy and bit 1 is WEL. A completion strobe whose opcode equals `wrenOpcode` while `wrenEn` is 1 sets bit 1 one cycle later.
- R3: A completion strobe whose opcode equals `wrdiOpcode` while `wrdiEn` is 1 clears bit 1 one cycle later. If the opcode matches both enabled opcodes, bit 1 ends up cleared.
- R4: A write-enable or write-disable opcode whose enable is 0 leaves `statusOut` unchanged.
- R5: A completion strobe with `cmdBusyAttr` set raises bit 0. Command completions never change bits 23:2.
- R6: With the host idle, `swWr` loads `swWrData` into all 24 bits one cycle later. If `swWr` and `swClr` are both asserted, the write wins.
- R7: With the host idle, `swClr` clears bits 1:0 and keeps bits 23:2.
- R8: When a software action takes effect in the same cycle as a command completion, the software result is applied last and wins.
- R9: While `hostActive` is 1, software requests do not change `statusOut`. The most recent request is held and applied in the first cycle with `hostActive` at 0.
- R10: `swCancel` discards the held request, so it is never applied.
- R11: `rdStart` captures into `hostByte` the byte chosen by `rdSel` from the status value before that cycle's update. `rdSel` 0 selects bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16, and 3 gives 0x00. `hostByte` holds that byte until the next `rdStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdDone | input | 1 | Single-cycle strobe: a decoded command has completed |
| cmdOpcode | input | 8 | Opcode of the completed command |
| cmdBusyAttr | input | 1 | The completed command's slot sets busy |
| wrenEn | input | 1 | Enables the write-enable opcode match |
| wrenOpcode | input | 8 | Opcode that sets WEL |
| wrdiEn | input | 1 | Enables the write-disable opcode match |
| wrdiOpcode | input | 8 | Opcode that clears WEL |
| hostActive | input | 1 | The host has a transaction open |
| swWr | input | 1 | Software request: write the full word |
| swWrData | input | 24 | Data for the software full write |
| swClr | input | 1 | Software request: clear busy and WEL |
| swCancel | input | 1 | Discard the held software request |
| rdStart | input | 1 | Strobe: a read-status command is starting |
| rdSel | input | 2 | Index of the status byte to serve |
| statusOut | output | 24 | Current status word |
| hostByte | output | 8 | Status byte captured for the host |

## Verification
The assertions assume that `cmdDone` and `rdStart` are single-cycle strobes and that the configuration opcodes and enables stay constant while a completion is in flight. The bench therefore drives every strobe for exactly one cycle, starting from a negative edge. It changes the opcode configuration only in cycles with no completion.

The hold and cancel properties assume that `hostActive` is a plain level. The stimulus raises it across several cycles and posts requests inside that window. It also places software actions in the same cycle as command completions and read starts, which exercises the priority order.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;

  typedef struct packed {
    logic hwSetWel;
    logic hwClrWel;
    logic hwSetBusy;
    logic swLoad;
    logic swClear;
    logic snap;
  } fse_strobe_t;
endpackage

// File: rtl/fse_opmatch.sv
module fse_opmatch #(
  parameter int OPC_W = 8
) (
  input  logic             cmdDone,
  input  logic [OPC_W-1:0] cmdOpcode,
  input  logic             refEn,
  input  logic [OPC_W-1:0] refOpcode,
  output logic             hit
);
  assign hit = cmdDone && refEn && (cmdOpcode == refOpcode);
endmodule

// File: rtl/fse_ctrl.sv
module fse_ctrl
  import fse_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int STAT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdDone,
  input  logic [OPC_W-1:0]  cmdOpcode,
  input  logic              cmdBusyAttr,
  input  logic              wrenEn,
  input  logic [OPC_W-1:0]  wrenOpcode,
  input  logic              wrdiEn,
  input  logic [OPC_W-1:0]  wrdiOpcode,
  input  logic              hostActive,
  input  logic              swWr,
  input  logic [STAT_W-1:0] swWrData,
  input  logic              swClr,
  input  logic              swCancel,
  input  logic              rdStart,
  output fse_strobe_t       strobes,
  output logic [STAT_W-1:0] loadData
);
  localparam int NUM_MATCH = 2;

  logic [NUM_MATCH-1:0]            matchHit;
  logic [NUM_MATCH-1:0]            matchEn;
  logic [NUM_MATCH-1:0][OPC_W-1:0] matchOp;

  // index 0: write-enable, index 1: write-disable
  assign matchEn = {wrdiEn, wrenEn};
  assign matchOp = {wrdiOpcode, wrenOpcode};

  for (genvar g = 0; g < NUM_MATCH; g++) begin : gMatch
    fse_opmatch #(.OPC_W(OPC_W)) u_match (
      .cmdDone  (cmdDone),
      .cmdOpcode(cmdOpcode),
      .refEn    (matchEn[g]),
      .refOpcode(matchOp[g]),
      .hit      (matchHit[g])
    );
  end

  logic              pendValid;
  logic              pendIsWrite;
  logic [STAT_W-1:0] pendData;

  logic directWr;
  logic directClr;
  logic pendApply;

  always_comb begin
    directWr  = !hostActive && swWr;
    directClr = !hostActive && !swWr && swClr;
    pendApply = !hostActive && pendValid && !swCancel && !swWr && !swClr;

    strobes.hwSetWel  = matchHit[0] && !matchHit[1];
    strobes.hwClrWel  = matchHit[1];
    strobes.hwSetBusy = cmdDone && cmdBusyAttr;
    strobes.swLoad    = directWr  || (pendApply && pendIsWrite);
    strobes.swClear   = directClr || (pendApply && !pendIsWrite);
    strobes.snap      = rdStart;
    loadData          = directWr ? swWrData : pendData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid   <= 1'b0;
      pendIsWrite <= 1'b0;
      pendData    <= '0;
    end else if (!hostActive) begin
      pendValid <= 1'b0;
    end else if (swCancel) begin
      pendValid <= 1'b0;
    end else if (swWr) begin
      pendValid   <= 1'b1;
      pendIsWrite <= 1'b1;
      pendData    <= swWrData;
    end else if (swClr) begin
      pendValid   <= 1'b1;
      pendIsWrite <= 1'b0;
    end
  end

  // R9: nothing from software reaches the word while the host is active
  a_r9_hold_while_active: assert property (@(posedge clk) disable iff (!rstN)
    hostActive |-> !(strobes.swLoad || strobes.swClear));

  // R9: a held request is applied once the host goes idle
  a_r9_apply_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!hostActive && pendValid && !swCancel) |-> (strobes.swLoad || strobes.swClear));

  // R10: cancel leaves nothing pending
  a_r10_cancel_drops: assert property (@(posedge clk) disable iff (!rstN)
    swCancel |=> !pendValid);
endmodule

// File: rtl/fse_datapath.sv
module fse_datapath
  import fse_pkg::*;
#(
  parameter int STAT_BYTES = 3,
  parameter int SEL_W      = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fse_strobe_t               strobes,
  input  logic [STAT_BYTES*8-1:0]   loadData,
  input  logic [SEL_W-1:0]          rdSel,
  output logic [STAT_BYTES*8-1:0]   statusQ,
  output logic [7:0]                hostByte
);
  localparam int STAT_W = STAT_BYTES * 8;

  logic [STAT_W-1:0] statusNext;
  logic [7:0]        selByte;

  always_comb begin
    statusNext = statusQ;
    if (strobes.hwSetWel)  statusNext[WEL_BIT]  = 1'b1;
    if (strobes.hwClrWel)  statusNext[WEL_BIT]  = 1'b0;
    if (strobes.hwSetBusy) statusNext[BUSY_BIT] = 1'b1;
    if (strobes.swLoad) begin
      statusNext = loadData;
    end else if (strobes.swClear) begin
      statusNext[BUSY_BIT] = 1'b0;
      statusNext[WEL_BIT]  = 1'b0;
    end
  end

  always_comb begin
    selByte = 8'h00;
    for (int i = 0; i < STAT_BYTES; i++) begin
      if (rdSel == SEL_W'(i)) selByte = statusQ[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      hostByte <= 8'h00;
    end else begin
      statusQ <= statusNext;
      if (strobes.snap) hostByte <= selByte;
    end
  end

  // R5: upper bits move only through software
  a_r5_upper_hw_free: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.swLoad || strobes.swClear) |=> statusQ[STAT_W-1:2] == $past(statusQ[STAT_W-1:2]));

  // R2: write-enable without software override sets WEL
  a_r2_wel_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hwSetWel && !strobes.swLoad && !strobes.swClear) |=> statusQ[WEL_BIT]);

  // R3: write-disable without software override clears WEL
  a_r3_wel_clr: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hwClrWel && !strobes.swLoad && !strobes.swClear) |=> !statusQ[WEL_BIT]);

  // R6 / R8: software load lands in full
  a_r6_full_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swLoad |=> statusQ == $past(loadData));

  // R7: software clear zeroes busy and WEL
  a_r7_clear_pair: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.swClear && !strobes.swLoad) |=> (statusQ[1:0] == 2'b00));

  // R11: served byte holds between read starts
  a_r11_byte_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.snap |=> $stable(hostByte));
endmodule

// File: rtl/flash_status_emu.sv
module flash_status_emu
  import fse_pkg::*;
#(
  parameter int STAT_BYTES = 3,
  parameter int OPC_W      = 8,
  localparam int STAT_W    = STAT_BYTES * 8,
  localparam int SEL_W     = $clog2(STAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdDone,
  input  logic [OPC_W-1:0]  cmdOpcode,
  input  logic              cmdBusyAttr,
  input  logic              wrenEn,
  input  logic [OPC_W-1:0]  wrenOpcode,
  input  logic              wrdiEn,
  input  logic [OPC_W-1:0]  wrdiOpcode,
  input  logic              hostActive,
  input  logic              swWr,
  input  logic [STAT_W-1:0] swWrData,
  input  logic              swClr,
  input  logic              swCancel,
  input  logic              rdStart,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [STAT_W-1:0] statusOut,
  output logic [7:0]        hostByte
);
  fse_strobe_t       strobes;
  logic [STAT_W-1:0] loadData;

  fse_ctrl #(.OPC_W(OPC_W), .STAT_W(STAT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdDone    (cmdDone),
    .cmdOpcode  (cmdOpcode),
    .cmdBusyAttr(cmdBusyAttr),
    .wrenEn     (wrenEn),
    .wrenOpcode (wrenOpcode),
    .wrdiEn     (wrdiEn),
    .wrdiOpcode (wrdiOpcode),
    .hostActive (hostActive),
    .swWr       (swWr),
    .swWrData   (swWrData),
    .swClr      (swClr),
    .swCancel   (swCancel),
    .rdStart    (rdStart),
    .strobes    (strobes),
    .loadData   (loadData)
  );

  fse_datapath #(.STAT_BYTES(STAT_BYTES), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadData(loadData),
    .rdSel   (rdSel),
    .statusQ (statusOut),
    .hostByte(hostByte)
  );
endmodule

// File: tb/flash_status_emu_tb.sv
`timescale 1ns/1ps
module flash_status_emu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdDone = 0, cmdBusyAttr = 0;
  logic [7:0]  cmdOpcode = 0;
  logic        wrenEn = 1, wrdiEn = 1;
  logic [7:0]  wrenOpcode = 8'h06, wrdiOpcode = 8'h04;
  logic        hostActive = 0, swWr = 0, swClr = 0, swCancel = 0, rdStart = 0;
  logic [23:0] swWrData = 0;
  logic [1:0]  rdSel = 0;
  logic [23:0] statusOut;
  logic [7:0]  hostByte;

  int    nChk = 0, nFail = 0;
  string curReq = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  flash_status_emu u_dut (
    .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .cmdOpcode(cmdOpcode),
    .cmdBusyAttr(cmdBusyAttr), .wrenEn(wrenEn), .wrenOpcode(wrenOpcode),
    .wrdiEn(wrdiEn), .wrdiOpcode(wrdiOpcode), .hostActive(hostActive),
    .swWr(swWr), .swWrData(swWrData), .swClr(swClr), .swCancel(swCancel),
    .rdStart(rdStart), .rdSel(rdSel), .statusOut(statusOut), .hostByte(hostByte)
  );

  // behavioural reference model
  logic [23:0] mStat;
  logic [7:0]  mByte;
  bit          mPend, mPendWr;
  logic [23:0] mPendData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = 0; mByte = 0; mPend = 0; mPendWr = 0; mPendData = 0;
    end else begin
      logic [23:0] nxt;
      if (rdStart) mByte = (rdSel == 2'd3) ? 8'h00 : 8'((mStat >> (8 * rdSel)) & 24'hFF);
      nxt = mStat;
      if (cmdDone) begin
        if (wrenEn && cmdOpcode == wrenOpcode) nxt = nxt | 24'h2;
        if (wrdiEn && cmdOpcode == wrdiOpcode) nxt = nxt & ~24'h2;
        if (cmdBusyAttr) nxt = nxt | 24'h1;
      end
      if (!hostActive) begin
        if (swWr) nxt = swWrData;
        else if (swClr) nxt = nxt & ~24'h3;
        else if (mPend && !swCancel) nxt = mPendWr ? mPendData : (nxt & ~24'h3);
        mPend = 0;
      end else if (swCancel) mPend = 0;
      else if (swWr) begin mPend = 1; mPendWr = 1; mPendData = swWrData; end
      else if (swClr) begin mPend = 1; mPendWr = 0; end
      mStat = nxt;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    chk({curReq, " model status"}, 32'(statusOut), 32'(mStat));
    chk({curReq, " model byte"},   32'(hostByte),  32'(mByte));
  end

  task automatic idle();
    cmdDone = 0; cmdBusyAttr = 0; cmdOpcode = 0; hostActive = 0;
    swWr = 0; swClr = 0; swCancel = 0; rdStart = 0; rdSel = 0; swWrData = 0;
  endtask

  task automatic go();
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] op, logic busy);
    idle(); cmdDone = 1; cmdOpcode = op; cmdBusyAttr = busy; go();
  endtask

  task automatic swWrite(logic [23:0] d);
    idle(); swWr = 1; swWrData = d; go();
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1";
    chk("R1 reset status", 32'(statusOut), 32'h0);
    chk("R1 reset byte", 32'(hostByte), 32'h0);

    curReq = "R2"; cmd(8'h06, 0);
    chk("R2 WREN sets WEL", 32'(statusOut), 32'h000002);
    curReq = "R5"; cmd(8'h02, 1);
    chk("R5 busy attr sets busy", 32'(statusOut), 32'h000003);
    curReq = "R3"; cmd(8'h04, 0);
    chk("R3 WRDI clears WEL", 32'(statusOut), 32'h000001);

    curReq = "R4"; idle(); wrenEn = 0; go();
    cmd(8'h06, 0);
    chk("R4 disabled WREN ignored", 32'(statusOut), 32'h000001);
    idle(); wrenEn = 1; go();

    curReq = "R6"; swWrite(24'hA5C3F0);
    chk("R6 full write", 32'(statusOut), 32'hA5C3F0);
    idle(); swWr = 1; swClr = 1; swWrData = 24'h123457; go();
    chk("R6 write beats clear", 32'(statusOut), 32'h123457);
    curReq = "R7"; idle(); swClr = 1; go();
    chk("R7 clear busy+WEL", 32'(statusOut), 32'h123454);

    curReq = "R5"; cmd(8'h06, 1);
    chk("R5 upper bits untouched", 32'(statusOut), 32'h123457);

    curReq = "R8"; idle(); cmdDone = 1; cmdOpcode = 8'h06; cmdBusyAttr = 1;
    swWr = 1; swWrData = 24'h000100; go();
    chk("R8 sw write wins", 32'(statusOut), 32'h000100);
    idle(); cmdDone = 1; cmdOpcode = 8'h06; cmdBusyAttr = 1; swClr = 1; go();
    chk("R8 sw clear wins", 32'(statusOut), 32'h000100);

    curReq = "R11"; idle(); rdStart = 1; rdSel = 1; swWr = 1; swWrData = 24'hFFEEDD; go();
    chk("R11 pre-update byte", 32'(hostByte), 32'h01);
    idle(); rdStart = 1; rdSel = 2; go();
    chk("R11 byte 2", 32'(hostByte), 32'hFF);
    idle(); rdStart = 1; rdSel = 3; go();
    chk("R11 index 3 gives zero", 32'(hostByte), 32'h00);
    swWrite(24'h123456); swWrite(24'h654321);
    chk("R11 byte held", 32'(hostByte), 32'h00);
    idle(); rdStart = 1; rdSel = 0; go();
    chk("R11 byte 0", 32'(hostByte), 32'h21);

    curReq = "R9"; idle(); hostActive = 1; swWr = 1; swWrData = 24'h00AA00; go();
    idle(); hostActive = 1; go();
    chk("R9 held while active", 32'(statusOut), 32'h654321);
    idle(); hostActive = 1; swWr = 1; swWrData = 24'h00BB00; go();
    idle(); hostActive = 1; cmdDone = 1; cmdOpcode = 8'h04; go();
    chk("R9 still held", 32'(statusOut), 32'h654321);
    idle(); go();
    chk("R9 latest request applied", 32'(statusOut), 32'h00BB00);

    curReq = "R10"; swWrite(24'h000003);
    idle(); hostActive = 1; swClr = 1; go();
    idle(); hostActive = 1; swCancel = 1; go();
    idle(); go(); go();
    chk("R10 cancelled clear", 32'(statusOut), 32'h000003);
    idle(); hostActive = 1; swWr = 1; swWrData = 24'h777777; go();
    idle(); swCancel = 1; go();
    chk("R10 cancel on idle edge", 32'(statusOut), 32'h000003);

    curReq = "R3"; idle(); wrdiOpcode = 8'h06; go();
    cmd(8'h06, 0);
    chk("R3 WRDI wins over WREN", 32'(statusOut), 32'h000001);
    idle(); wrdiOpcode = 8'h04; go();

    finishRun();
  end
endmodule